// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Status Flags

This block buffers a stream of words between a producer and a consumer that run on two unrelated, free-running clocks. Words go into a small dual-port storage array. Each side keeps its own binary address counter, and the counter wraps naturally at a power-of-two depth. The producer offers a word with a write enable. The consumer takes the oldest word with a read enable and finds it in an output register, which keeps its value until the next accepted read.

Each side sees only the flags that belong to it, and those flags change only on that side's clock. The producer gets full, half-full and almost-full. The consumer gets empty and almost-empty. Each side learns the other side's position through a Gray-coded pointer that passes through a multi-stage synchronizer. A flag set by a side's own operation is therefore updated on that same edge. A flag cleared by the far side's activity clears a few cycles later. The almost-full and almost-empty levels are taken from configuration inputs while the owning side is held in reset, and they keep those values until the next reset.

Top module: `xclk_fifo`

## Requirements
- R1: On a rising write clock edge with wr_en high and full low, wr_data is stored and the write pointer advances by one. Otherwise nothing is stored.
- R2: On a rising read clock edge with rd_en high and empty low, the oldest stored word is loaded into rd_data. rd_data keeps its value on every other edge.
- R3: During reset and after it, empty=1, almost_empty=1, full=0, half_full=0, almost_full=0 and rd_data=0.
- R4: A write while full and a read while empty are ignored. No pointer moves, no stored word is overwritten and rd_data is unchanged.
- R5: full rises on the write clock edge that stores the DEPTH-th word. empty rises on the read clock edge that removes the last word. Neither is delayed.
- R6: A release caused by the other side is delayed by the three-stage synchronizer. full stays high for at least two write clock edges after the read that frees a slot. empty stays high for at least two read clock edges after the first write. Each clears within five edges of its own clock.
- R7: When no reads are pending in the synchronizer, half_full is high exactly when the stored count is at least DEPTH/2.
- R8: almost_full is high when the write-side count is at least the level loaded from cfg_af_lvl. almost_empty is high when the read-side count is at most the level loaded from cfg_ae_lvl. Each level is captured on clock edges while that side's reset is low. Changes to the configuration inputs after reset have no effect.
- R9: When both clocks run at unrelated rates with reads and writes overlapping, every word comes out once, in the order it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to store |
| cfg_af_lvl | input | AW+1 | Almost-full level, captured during write reset |
| full | output | 1 | No free slot (write domain) |
| half_full | output | 1 | At least half the slots used (write domain) |
| almost_full | output | 1 | Count at or above the loaded level (write domain) |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side reset, active low |
| rd_en | input | 1 | Read request |
| cfg_ae_lvl | input | AW+1 | Almost-empty level, captured during read reset |
| rd_data | output | DW | Registered oldest word |
| empty | output | 1 | No stored word (read domain) |
| almost_empty | output | 1 | Count at or below the loaded level (read domain) |

## Verification
The hardest case to reach from the ports is the window in which a flag has already been released by the other side but the owning side has not yet seen the release. This window lasts only the synchronizer latency, and the periods of the two clocks are never in a whole-number ratio. The bench sets the write clock at 10 and the read clock at 14 with a fractional phase offset, so their edges never coincide. It then samples full a fixed number of write edges after a single read, and empty a fixed number of read edges after a single write. A sweep over every almost-full level, with almost-empty one below it, fills past full and drains past empty, so every count and every ignored operation is visited.

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo #(
  parameter int DW   = 8,
  parameter int AW   = 3,
  parameter int SYNC = 3
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [AW:0]   cfg_af_lvl,
  output logic          full,
  output logic          half_full,
  output logic          almost_full,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  input  logic [AW:0]   cfg_ae_lvl,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          almost_empty
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_CNT = (AW+1)'(DEPTH/2);
  localparam logic [AW:0] ONE      = (AW+1)'(1);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW-1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [AW:0] b2g(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0] wbin, wgray, rbin, rgray;
  logic [AW:0] rg_s [SYNC];
  logic [AW:0] wg_s [SYNC];
  logic [AW:0] af_lvl, ae_lvl;

  // write domain
  logic        wpush;
  logic [AW:0] wbin_nx, wcnt_nx;
  assign wpush   = wr_en & ~full;
  assign wbin_nx = wpush ? wbin + ONE : wbin;
  assign wcnt_nx = wbin_nx - g2b(rg_s[SYNC-1]);

  always_ff @(posedge wclk)
    if (!wrst_n) af_lvl <= cfg_af_lvl;

  always_ff @(posedge wclk)
    if (wpush) mem[wbin[AW-1:0]] <= wr_data;

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      for (int k = 0; k < SYNC; k++) rg_s[k] <= '0;
    end else begin
      rg_s[0] <= rgray;
      for (int k = 1; k < SYNC; k++) rg_s[k] <= rg_s[k-1];
    end

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      wbin        <= '0;
      wgray       <= '0;
      full        <= 1'b0;
      half_full   <= 1'b0;
      almost_full <= 1'b0;
    end else begin
      wbin        <= wbin_nx;
      wgray       <= b2g(wbin_nx);
      full        <= (wcnt_nx == FULL_CNT);
      half_full   <= (wcnt_nx >= HALF_CNT);
      almost_full <= (wcnt_nx >= af_lvl);
    end

  // read domain
  logic        rpop;
  logic [AW:0] rbin_nx, rcnt_nx;
  assign rpop    = rd_en & ~empty;
  assign rbin_nx = rpop ? rbin + ONE : rbin;
  assign rcnt_nx = g2b(wg_s[SYNC-1]) - rbin_nx;

  always_ff @(posedge rclk)
    if (!rrst_n) ae_lvl <= cfg_ae_lvl;

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      for (int k = 0; k < SYNC; k++) wg_s[k] <= '0;
    end else begin
      wg_s[0] <= wgray;
      for (int k = 1; k < SYNC; k++) wg_s[k] <= wg_s[k-1];
    end

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      rbin         <= '0;
      rgray        <= '0;
      rd_data      <= '0;
      empty        <= 1'b1;
      almost_empty <= 1'b1;
    end else begin
      rbin         <= rbin_nx;
      rgray        <= b2g(rbin_nx);
      if (rpop) rd_data <= mem[rbin[AW-1:0]];
      empty        <= (rcnt_nx == '0);
      almost_empty <= (rcnt_nx <= ae_lvl);
    end
endmodule

// File: rtl/xclk_fifo_chk.sv
`timescale 1ns/1ps
module xclk_fifo_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          wclk,
  input logic          wrst_n,
  input logic          wr_en,
  input logic          full,
  input logic          half_full,
  input logic [AW:0]   wbin,
  input logic          rclk,
  input logic          rrst_n,
  input logic          rd_en,
  input logic          empty,
  input logic          almost_empty,
  input logic [AW:0]   rbin,
  input logic [DW-1:0] rd_data
);
  localparam logic [AW:0] ONE = (AW+1)'(1);

  a_r1_write_advances: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && !full) |=> (wbin == $past(wbin) + ONE));

  a_r4_full_write_ignored: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && full) |=> (wbin == $past(wbin)));

  a_r2_read_advances: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && !empty) |=> (rbin == $past(rbin) + ONE));

  a_r4_empty_read_ignored: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && empty) |=> ((rbin == $past(rbin)) && $stable(rd_data)));

  a_r7_full_has_half: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |-> half_full);

  a_r8_empty_has_almost_empty: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty |-> almost_empty);
endmodule

bind xclk_fifo xclk_fifo_chk #(.DW(DW), .AW(AW)) chk_i (
  .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .full(full), .half_full(half_full),
  .wbin(wbin), .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .empty(empty),
  .almost_empty(almost_empty), .rbin(rbin), .rd_data(rd_data)
);

// File: tb/xclk_fifo_tb_top.sv
`timescale 1ns/100ps
module xclk_fifo_tb_top;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam realtime WCLK_PERIOD = 10.0;
  localparam realtime RCLK_PERIOD = 14.0;
  localparam int STREAM_N = 60;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst_n = 1'b0, rrst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [AW:0] cfg_af_lvl = '0, cfg_ae_lvl = '0;
  logic full, half_full, almost_full, empty, almost_empty;
  logic [DW-1:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;

  xclk_fifo #(.DW(DW), .AW(AW), .SYNC(3)) dut_i (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_af_lvl(cfg_af_lvl), .full(full), .half_full(half_full),
    .almost_full(almost_full), .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en),
    .cfg_ae_lvl(cfg_ae_lvl), .rd_data(rd_data), .empty(empty),
    .almost_empty(almost_empty)
  );

  initial forever #(WCLK_PERIOD/2) wclk = ~wclk;
  initial begin
    #1.5;
    forever #(RCLK_PERIOD/2) rclk = ~rclk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int p, input int i);
    return DW'(p * 37 + i * 11 + 5);
  endfunction

  task automatic do_reset(input int af, input int ae);
    wr_en = 1'b0; rd_en = 1'b0;
    wrst_n = 1'b0; rrst_n = 1'b0;
    cfg_af_lvl = (AW+1)'(af); cfg_ae_lvl = (AW+1)'(ae);
    repeat (4) @(posedge rclk);
    chk("R3 empty in reset", int'(empty), 1);
    chk("R3 full in reset", int'(full), 0);
    @(negedge wclk) wrst_n = 1'b1;
    @(negedge rclk) rrst_n = 1'b1;
    // R8: later changes to the level inputs must have no effect
    cfg_af_lvl = '0; cfg_ae_lvl = (AW+1)'(DEPTH);
    repeat (2) @(negedge wclk);
    chk("R3 full after reset", int'(full), 0);
    chk("R3 half_full after reset", int'(half_full), 0);
    chk("R3 almost_full after reset", int'(almost_full), 0);
    @(negedge rclk);
    chk("R3 empty after reset", int'(empty), 1);
    chk("R3 almost_empty after reset", int'(almost_empty), 1);
    chk("R3 rd_data after reset", int'(rd_data), 0);
  endtask

  task automatic wr_one(input logic [DW-1:0] d);
    @(negedge wclk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge wclk) wr_en = 1'b0;
  endtask

  task automatic rd_one;
    @(negedge rclk) rd_en = 1'b1;
    @(negedge rclk) rd_en = 1'b0;
  endtask

  task automatic run_pass(input int p, input int af, input int ae);
    int k, m;
    do_reset(af, ae);
    for (int i = 0; i < DEPTH + 2; i++) begin
      wr_one(pat(p, i));
      k = (i + 1 < DEPTH) ? i + 1 : DEPTH;
      chk("R5 full on own write", int'(full), int'(k == DEPTH));
      chk("R7 half_full by count", int'(half_full), int'(k >= DEPTH/2));
      chk("R8 almost_full by loaded level", int'(almost_full), int'(k >= af));
      if (i == 0) begin
        repeat (2) @(posedge rclk);
        @(negedge rclk);
        chk("R6 empty release delayed", int'(empty), 1);
      end
    end
    repeat (6) @(negedge rclk);
    chk("R6 empty released", int'(empty), 0);
    chk("R8 almost_empty at full count", int'(almost_empty), int'(DEPTH <= ae));
    for (int r = 1; r <= DEPTH + 2; r++) begin
      rd_one();
      m = (DEPTH - r > 0) ? DEPTH - r : 0;
      chk("R2 R4 read data order", int'(rd_data),
          int'(pat(p, (r <= DEPTH) ? r - 1 : DEPTH - 1)));
      chk("R5 empty on own read", int'(empty), int'(m == 0));
      chk("R8 almost_empty by loaded level", int'(almost_empty), int'(m <= ae));
      if (r == 1) begin
        repeat (2) @(posedge wclk);
        @(negedge wclk);
        chk("R6 full release delayed", int'(full), 1);
        repeat (4) @(negedge wclk);
        chk("R6 full released", int'(full), 0);
      end
    end
    repeat (6) @(negedge wclk);
    chk("R7 half_full cleared", int'(half_full), 0);
    chk("R8 almost_full cleared", int'(almost_full), 0);
  endtask

  task automatic stream_test;
    int wi, rj;
    logic pend;
    wi = 0; rj = 0; pend = 1'b0;
    do_reset(6, 2);
    fork
      begin
        while (wi < STREAM_N) begin
          @(negedge wclk);
          if (!full) begin
            wr_en = 1'b1; wr_data = pat(99, wi); wi++;
          end else wr_en = 1'b0;
        end
        @(negedge wclk) wr_en = 1'b0;
      end
      begin
        while (rj < STREAM_N) begin
          @(negedge rclk);
          if (pend) begin
            chk("R9 streaming order", int'(rd_data), int'(pat(99, rj)));
            rj++;
          end
          pend  = !empty && (rj + int'(!empty) <= STREAM_N);
          rd_en = pend;
        end
        rd_en = 1'b0;
      end
    join
    repeat (8) @(negedge rclk);
    chk("R9 empty after stream", int'(empty), 1);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int af = 1; af <= DEPTH; af++) run_pass(af, af, af - 1);
    stream_test();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule